// File: doc/BRIEF.md
# Sixteen-Channel PWM Bank with Period-Aligned Duty Loading

This block drives sixteen pulse outputs from one clock and one shared time base. A prescaler divides the clock into ticks, and a period counter steps once per tick from zero up to a programmable terminal value, then returns to zero. Each channel holds two edge values, a rise point and a fall point. In normal mode the channel output is high while the counter lies between them.

Software programs the bank through an APB slave. Two build-time masks shape each channel. The first mask gives a channel a second, active copy of its edge values. When a single run-time bit enables deferred loading, writes to such a channel wait in the programmed copy and move into the active copy on the clock where the counter wraps. All deferred channels move on the same clock. Channels without the copy apply writes at once, whatever the bit says.

The second mask turns a channel into a low-ripple DAC. In that mode the channel ignores its rise point and feeds its fall point into a first-order accumulator once per tick. The result is a dense stream of one-tick pulses whose average matches the programmed level.

Top module: `pwm_bank`

## Requirements
- R1: While `presetn` is low, and until the second rising `pclk` after it goes high, every output is low and every register holds zero, including the deferred-load bit.
- R2: The register map is: prescale at 0x00, period terminal at 0x04, deferred-load enable in bit 0 of 0x08, rise point of channel n at 0x10+8n, fall point of channel n at 0x14+8n. A read returns the last written value truncated to the counter width. Any other address reads zero and ignores writes. `pready` is always high, so there are no wait states.
- R3: A tick occurs on every (prescale+1)-th clock. On each tick the counter advances by one, or returns to zero if it is at or above the terminal value. Between ticks it holds.
- R4: A normal channel output is high exactly when the counter is at or above the active rise point and below the active fall point. Equal points give a constant low.
- R5: A write to a channel that has no active copy, or to any channel while deferred loading is off, governs the output from the clock after the write.
- R6: With deferred loading on, a write to a channel that has an active copy does not affect its output until the wrap clock. A write that completes on the wrap clock itself is included. All such channels switch on that same clock.
- R7: The deferred-load bit has no effect on channels built without an active copy.
- R8: On each tick a DAC channel adds its active fall point, clamped to period+1, to an accumulator. If the sum reaches period+1, it subtracts period+1 and drives the output high for that tick; otherwise it drives the output low. The output changes only on ticks, and the rise point is ignored.
- R9: Over any period+1 consecutive ticks with a constant level, a DAC channel is high on exactly min(level, period+1) ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock for the bus and all channels |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write strobe |
| paddr | input | 8 | APB byte address within the window |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, held high |
| pwm_out | output | NCH | Channel outputs |

## Verification
The sharpest collision is an APB write to a channel with an active copy that completes on the same clock as the counter wrap, while deferred loading is on. The bench tracks the time base in a bench-side model and starts the write exactly one counter step before the terminal value, so that the access phase lands on the wrap. It then expects the new fall point to shape the period that has just begun, together with a value staged earlier on a second channel. The full outputs are also compared on every cycle against the model while random writes, sync toggles and period changes go on.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

  typedef logic [7:0] reg_addr_t;

  localparam reg_addr_t ADDR_PRESC  = 8'h00;
  localparam reg_addr_t ADDR_PERIOD = 8'h04;
  localparam reg_addr_t ADDR_SYNC   = 8'h08;
  localparam int unsigned CH_BASE   = 16;
  localparam int unsigned CH_STRIDE = 8;

  // Byte address of a channel edge register; fall_edge selects the second word.
  function automatic reg_addr_t ch_addr(int unsigned ch, bit fall_edge);
    return reg_addr_t'(CH_BASE + ch * CH_STRIDE + (fall_edge ? 4 : 0));
  endfunction

endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] presc,
  input  logic [CW-1:0] period,
  output logic          tick,
  output logic          wrap,
  output logic [CW-1:0] cnt
);

  logic [CW-1:0] pre_q, pre_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (pre_q >= presc);
    wrap  = tick && (cnt_q >= period);
    pre_d = tick ? '0 : pre_q + 1'b1;
    cnt_d = cnt_q;
    if (wrap)      cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned CW     = 16,
  parameter bit          SHADOW = 1'b0,
  parameter bit          DAC    = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_rise,
  input  logic          wr_fall,
  input  logic [CW-1:0] wdata,
  input  logic          sync_on,
  input  logic          tick,
  input  logic          wrap,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] stg_rise,
  output logic [CW-1:0] stg_fall,
  output logic [CW-1:0] act_rise,
  output logic [CW-1:0] act_fall,
  output logic          pwm
);

  logic [CW-1:0] rise_q, rise_d, fall_q, fall_d;

  always_comb begin
    rise_d = wr_rise ? wdata : rise_q;
    fall_d = wr_fall ? wdata : fall_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign stg_rise = rise_q;
  assign stg_fall = fall_q;

  generate
    if (SHADOW) begin : g_shadow
      logic [CW-1:0] arise_q, afall_q;
      logic          load;
      assign load = !sync_on || wrap;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          arise_q <= '0;
          afall_q <= '0;
        end else if (load) begin
          arise_q <= rise_d;
          afall_q <= fall_d;
        end
      end
      assign act_rise = arise_q;
      assign act_fall = afall_q;
    end else begin : g_direct
      logic unused_sync;
      assign unused_sync = sync_on ^ wrap;
      assign act_rise = rise_q;
      assign act_fall = fall_q;
    end
  endgenerate

  generate
    if (DAC) begin : g_dac
      logic [CW:0] acc_q, acc_d, modulus, level, sum;
      logic        bit_q, bit_d;
      logic        unused_dac;
      assign unused_dac = ^{cnt, act_rise};
      always_comb begin
        modulus = {1'b0, period} + 1'b1;
        level   = ({1'b0, act_fall} > modulus) ? modulus : {1'b0, act_fall};
        sum     = acc_q + level;
        acc_d   = acc_q;
        bit_d   = bit_q;
        if (tick) begin
          if (sum >= modulus) begin
            acc_d = sum - modulus;
            bit_d = 1'b1;
          end else begin
            acc_d = sum;
            bit_d = 1'b0;
          end
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc_q <= '0;
          bit_q <= 1'b0;
        end else begin
          acc_q <= acc_d;
          bit_q <= bit_d;
        end
      end
      assign pwm = bit_q;
    end else begin : g_pwm
      logic unused_pwm;
      assign unused_pwm = ^{tick, period};
      assign pwm = (cnt >= act_rise) && (cnt < act_fall);
    end
  endgenerate

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_pkg::*;
#(
  parameter int unsigned    NCH         = 16,
  parameter int unsigned    CW          = 16,
  parameter logic [NCH-1:0] SHADOW_MASK = 16'h00FF,
  parameter logic [NCH-1:0] DAC_MASK    = 16'h8000
) (
  input  logic           pclk,
  input  logic           presetn,
  input  logic           psel,
  input  logic           penable,
  input  logic           pwrite,
  input  logic [7:0]     paddr,
  input  logic [31:0]    pwdata,
  output logic [31:0]    prdata,
  output logic           pready,
  output logic [NCH-1:0] pwm_out
);

  localparam int unsigned PAD = 32 - CW;

  // Reset: asserted asynchronously, released on the second clock edge.
  logic [1:0] rs_q;
  logic       rst_n;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) rs_q <= 2'b00;
    else          rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  logic          wr_en;
  logic [CW-1:0] wval;
  logic          unused_wdata;
  assign wr_en        = psel && penable && pwrite;
  assign wval         = pwdata[CW-1:0];
  assign unused_wdata = ^pwdata;

  logic [CW-1:0] presc_q, presc_d, period_q, period_d;
  logic          sync_q, sync_d;

  always_comb begin
    presc_d  = presc_q;
    period_d = period_q;
    sync_d   = sync_q;
    if (wr_en && (paddr == ADDR_PRESC))  presc_d  = wval;
    if (wr_en && (paddr == ADDR_PERIOD)) period_d = wval;
    if (wr_en && (paddr == ADDR_SYNC))   sync_d   = pwdata[0];
  end

  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q  <= '0;
      period_q <= '0;
      sync_q   <= 1'b0;
    end else begin
      presc_q  <= presc_d;
      period_q <= period_d;
      sync_q   <= sync_d;
    end
  end

  logic          tick, wrap;
  logic [CW-1:0] cnt;

  pwm_timebase #(.CW(CW)) u_tb (
    .clk    (pclk),
    .rst_n  (rst_n),
    .presc  (presc_q),
    .period (period_q),
    .tick   (tick),
    .wrap   (wrap),
    .cnt    (cnt)
  );

  logic [CW-1:0]     stg_rise [NCH];
  logic [CW-1:0]     stg_fall [NCH];
  logic [NCH*CW-1:0] act_rise_all, act_fall_all;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic wr_rise, wr_fall;
      assign wr_rise = wr_en && (paddr == ch_addr(i, 1'b0));
      assign wr_fall = wr_en && (paddr == ch_addr(i, 1'b1));
      pwm_chan #(
        .CW     (CW),
        .SHADOW (SHADOW_MASK[i]),
        .DAC    (DAC_MASK[i])
      ) u_chan (
        .clk      (pclk),
        .rst_n    (rst_n),
        .wr_rise  (wr_rise),
        .wr_fall  (wr_fall),
        .wdata    (wval),
        .sync_on  (sync_q),
        .tick     (tick),
        .wrap     (wrap),
        .cnt      (cnt),
        .period   (period_q),
        .stg_rise (stg_rise[i]),
        .stg_fall (stg_fall[i]),
        .act_rise (act_rise_all[i*CW +: CW]),
        .act_fall (act_fall_all[i*CW +: CW]),
        .pwm      (pwm_out[i])
      );
    end
  endgenerate

  logic [CW-1:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (paddr == ADDR_PRESC)  rd_val = presc_q;
    if (paddr == ADDR_PERIOD) rd_val = period_q;
    if (paddr == ADDR_SYNC)   rd_val = {{(CW-1){1'b0}}, sync_q};
    for (int i = 0; i < NCH; i++) begin
      if (paddr == ch_addr(i, 1'b0)) rd_val = stg_rise[i];
      if (paddr == ch_addr(i, 1'b1)) rd_val = stg_fall[i];
    end
  end

  assign prdata = {{PAD{1'b0}}, rd_val};
  assign pready = 1'b1;

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int unsigned    NCH         = 16,
  parameter int unsigned    CW          = 16,
  parameter logic [NCH-1:0] SHADOW_MASK = 16'h00FF,
  parameter logic [NCH-1:0] DAC_MASK    = 16'h8000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              wrap,
  input logic              sync_on,
  input logic [CW-1:0]     cnt,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH*CW-1:0] act_rise_all,
  input logic [NCH*CW-1:0] act_fall_all
);

  // R3
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

  // R3
  hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_c
      if (DAC_MASK[i]) begin : g_d
        // R8
        dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !tick |=> $stable(pwm_out[i]));
      end else begin : g_n
        // R4
        equal_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (act_rise_all[i*CW +: CW] == act_fall_all[i*CW +: CW]) |-> !pwm_out[i]);
      end
      if (SHADOW_MASK[i]) begin : g_s
        // R6
        shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (sync_on && !wrap) |=> ($stable(act_rise_all[i*CW +: CW]) &&
                                  $stable(act_fall_all[i*CW +: CW])));
      end
    end
  endgenerate

endmodule

bind pwm_bank pwm_bank_chk #(
  .NCH         (NCH),
  .CW          (CW),
  .SHADOW_MASK (SHADOW_MASK),
  .DAC_MASK    (DAC_MASK)
) u_chk (
  .clk          (pclk),
  .rst_n        (rst_n),
  .tick         (tick),
  .wrap         (wrap),
  .sync_on      (sync_q),
  .cnt          (cnt),
  .pwm_out      (pwm_out),
  .act_rise_all (act_rise_all),
  .act_fall_all (act_fall_all)
);

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;

  localparam int unsigned CLK_P = 10;
  localparam int unsigned NCH   = 16;
  localparam int unsigned CW    = 8;
  localparam logic [NCH-1:0] SHADOW = 16'h40FF;
  localparam logic [NCH-1:0] DACM   = 16'hC000;

  logic           clk, presetn, psel, penable, pwrite, pready;
  logic [7:0]     paddr;
  logic [31:0]    pwdata, prdata;
  logic [NCH-1:0] pwm_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_en = 0;
  bit done   = 0;

  pwm_bank #(.NCH(NCH), .CW(CW), .SHADOW_MASK(SHADOW), .DAC_MASK(DACM)) u_dut (
    .pclk(clk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- requirement-level model ----------------
  logic [1:0]    m_rs;
  logic [CW-1:0] m_pre, m_cnt, m_presc, m_period;
  logic          m_sync;
  logic [CW-1:0] m_rise [NCH];
  logic [CW-1:0] m_fall [NCH];
  logic [CW-1:0] m_arise [NCH];
  logic [CW-1:0] m_afall [NCH];
  logic [CW:0]   m_acc [NCH];
  logic          m_bit [NCH];
  logic          m_wr, m_tk, m_wp;
  logic [CW-1:0] m_rn, m_fn;
  logic [CW:0]   m_mod, m_lv, m_sum;

  always @(posedge clk or negedge presetn) begin
    if (!presetn || !m_rs[1]) begin
      m_rs     <= presetn ? {m_rs[0], 1'b1} : 2'b00;
      m_pre    <= '0; m_cnt <= '0; m_presc <= '0; m_period <= '0; m_sync <= 1'b0;
      for (int i = 0; i < NCH; i++) begin
        m_rise[i] <= '0; m_fall[i] <= '0; m_arise[i] <= '0; m_afall[i] <= '0;
        m_acc[i] <= '0; m_bit[i] <= 1'b0;
      end
    end else begin
      m_wr = psel && penable && pwrite;
      m_tk = (m_pre >= m_presc);
      m_wp = m_tk && (m_cnt >= m_period);
      m_pre <= m_tk ? '0 : m_pre + 1'b1;
      m_cnt <= m_wp ? '0 : (m_tk ? m_cnt + 1'b1 : m_cnt);
      if (m_wr && paddr == 8'h00) m_presc  <= pwdata[CW-1:0];
      if (m_wr && paddr == 8'h04) m_period <= pwdata[CW-1:0];
      if (m_wr && paddr == 8'h08) m_sync   <= pwdata[0];
      for (int i = 0; i < NCH; i++) begin
        m_rn = (m_wr && paddr == 8'(16 + 8*i)) ? pwdata[CW-1:0] : m_rise[i];
        m_fn = (m_wr && paddr == 8'(20 + 8*i)) ? pwdata[CW-1:0] : m_fall[i];
        m_rise[i] <= m_rn;
        m_fall[i] <= m_fn;
        if (!SHADOW[i] || !m_sync || m_wp) begin
          m_arise[i] <= m_rn;
          m_afall[i] <= m_fn;
        end
        if (DACM[i] && m_tk) begin
          m_mod = {1'b0, m_period} + 1'b1;
          m_lv  = ({1'b0, m_afall[i]} > m_mod) ? m_mod : {1'b0, m_afall[i]};
          m_sum = m_acc[i] + m_lv;
          if (m_sum >= m_mod) begin m_acc[i] <= m_sum - m_mod; m_bit[i] <= 1'b1; end
          else begin m_acc[i] <= m_sum; m_bit[i] <= 1'b0; end
        end
      end
    end
  end

  function automatic logic exp_out(int i);
    if (DACM[i]) return m_bit[i];
    return (m_cnt >= m_arise[i]) && (m_cnt < m_afall[i]);
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      for (int i = 0; i < NCH; i++) begin
        if (DACM[i])                chk("R8 dac stream", 32'(pwm_out[i]), 32'(exp_out(i)));
        else if (SHADOW[i] && m_sync) chk("R6 deferred output", 32'(pwm_out[i]), 32'(exp_out(i)));
        else                        chk("R5 immediate output", 32'(pwm_out[i]), 32'(exp_out(i)));
      end
    end
  end

  // ---------------- bus tasks (called at a falling edge) ----------------
  task automatic apb_write(logic [7:0] a, logic [31:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apb_read(logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    #(CLK_P/4) d = prdata;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wait_cnt(logic [CW-1:0] v);
    while (m_cnt != v) @(negedge clk);
  endtask

  function automatic logic [7:0] rise_a(int ch); return 8'(16 + 8*ch); endfunction
  function automatic logic [7:0] fall_a(int ch); return 8'(20 + 8*ch); endfunction

  task automatic count_high(int ch, int n, output int hi);
    hi = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] rd;
    int hi, period_len;
    bit prev;
    void'($urandom(32'd1234));
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
    idle(3);
    chk("R1 outputs low in reset", 32'(pwm_out), 32'h0);
    presetn = 1'b1;
    @(negedge clk);
    chk("R1 outputs low during release", 32'(pwm_out), 32'h0);
    idle(2);
    apb_read(8'h04, rd); chk("R1 period reset", rd, 32'h0);
    apb_read(8'h08, rd); chk("R1 sync reset", rd, 32'h0);
    apb_read(fall_a(5), rd); chk("R1 edge reset", rd, 32'h0);
    chk("R2 pready high", 32'(pready), 32'h1);
    cmp_en = 1'b1;

    // R2 map and truncation
    apb_write(8'h04, 32'd9);
    apb_read(8'h04, rd); chk("R2 period readback", rd, 32'd9);
    apb_write(8'h00, 32'h1FF);
    apb_read(8'h00, rd); chk("R2 prescale truncated", rd, 32'hFF);
    apb_write(8'hE0, 32'h55);
    apb_read(8'hE0, rd); chk("R2 unmapped reads zero", rd, 32'h0);

    // R3 time base: prescale 2, terminal 9 -> 30 clocks per period, 3 high
    apb_write(8'h00, 32'd2);
    apb_write(fall_a(0), 32'd1);
    prev = pwm_out[0];
    while (!(pwm_out[0] && !prev)) begin prev = pwm_out[0]; @(negedge clk); end
    count_high(0, 30, hi);
    chk("R3 high ticks times prescale", 32'(hi), 32'd3);
    period_len = 0; prev = 1'b1;
    do begin prev = pwm_out[0]; @(negedge clk); period_len++; end
    while (!(pwm_out[0] && !prev) && period_len < 100);
    period_len = 0; prev = pwm_out[0];
    do begin prev = pwm_out[0]; @(negedge clk); period_len++; end
    while (!(pwm_out[0] && !prev) && period_len < 100);
    chk("R3 period length", 32'(period_len), 32'd30);
    apb_write(8'h00, 32'd0);

    // R9 / R8 DAC density on channel 15 (modulus 10)
    apb_write(fall_a(15), 32'd3); idle(2);
    count_high(15, 10, hi); chk("R9 density 3", 32'(hi), 32'd3);
    apb_write(rise_a(15), 32'd5); idle(2);
    count_high(15, 10, hi); chk("R8 rise point ignored", 32'(hi), 32'd3);
    apb_write(fall_a(15), 32'd0); idle(2);
    count_high(15, 10, hi); chk("R9 density 0", 32'(hi), 32'd0);
    apb_write(fall_a(15), 32'd12); idle(2);
    count_high(15, 10, hi); chk("R9 density clamped", 32'(hi), 32'd10);
    apb_write(fall_a(15), 32'd7); idle(2);
    count_high(15, 20, hi); chk("R9 density 7 over two windows", 32'(hi), 32'd14);

    // R4 compare window
    apb_write(rise_a(1), 32'd4); apb_write(fall_a(1), 32'd4);
    count_high(1, 10, hi); chk("R4 equal points low", 32'(hi), 32'd0);
    apb_write(rise_a(1), 32'd2); apb_write(fall_a(1), 32'd6);
    count_high(1, 10, hi); chk("R4 window width", 32'(hi), 32'd4);

    // R5 immediate on unshadowed channel
    apb_write(fall_a(8), 32'd10);
    chk("R5 immediate high", 32'(pwm_out[8]), 32'h1);

    // R6 deferred loading
    apb_write(8'h08, 32'h1);
    wait_cnt(2);
    apb_write(fall_a(4), 32'd3);
    chk("R6 staged value held", 32'(pwm_out[4]), 32'h0);
    apb_write(fall_a(8), 32'd0);
    chk("R7 unshadowed ignores sync bit", 32'(pwm_out[8]), 32'h0);
    wait_cnt(8);
    apb_write(fall_a(3), 32'd3);
    chk("R6 collision counter at zero", 32'(m_cnt), 32'h0);
    chk("R6 write on wrap clock applied", 32'(pwm_out[3]), 32'h1);
    chk("R6 staged channel switched together", 32'(pwm_out[4]), 32'h1);
    apb_read(fall_a(4), rd); chk("R2 staged readback", rd, 32'd3);

    // random phase
    for (int it = 0; it < 300; it++) begin
      int unsigned r, ch, fe, v;
      logic [7:0] a;
      r = $urandom_range(0, 19);
      if (r == 0)      apb_write(8'h08, 32'($urandom_range(0, 1)));
      else if (r == 1) apb_write(8'h04, 32'($urandom_range(3, 20)));
      else if (r == 2) apb_write(8'h00, 32'($urandom_range(0, 2)));
      else begin
        ch = $urandom_range(0, NCH - 1);
        fe = $urandom_range(0, 1);
        v  = $urandom_range(0, 22);
        a  = fe ? fall_a(int'(ch)) : rise_a(int'(ch));
        apb_write(a, 32'(v));
        apb_read(a, rd);
        chk("R2 random readback", rd, 32'(v));
      end
      idle(int'($urandom_range(0, 12)));
    end

    cmp_en = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule